// File: doc/BRIEF.md
# Link Power Monitor and Wake Generator

This block watches the power-status level that a link controller drives toward the physical layer. It measures how long that level stays inactive and acts on the length. A short dip is ignored. A dip of medium length leads to one reset pulse for the interface between the physical layer and the link when the level comes back. A long dip disables that interface, and the return of the level enables it again and sends the same reset pulse. The packet repeater path is outside this block and keeps running in every case.

While the link is powered down, the block drives a wake output that toggles at one eighth of the system clock rate. Three things start it: a link-on packet received for this node, a port event flag, or a timeout, power-fail or loop flag together with the watchdog flag. The wake output keeps toggling until the link reports power again. A bus reset stops it only when a link-on packet alone started it. The block also tells the rest of the physical layer when it may enter low-power mode. That is allowed when the interface is disabled, every port is idle and the link is unpowered.

Top module: `linkpwr_mon`

## Requirements
- R1: The power-status input passes through SYNC_STAGES flip-flops (default 2) before any measurement. An inactive run of fewer than RST_CYC cycles (default 59) at the synchroniser output does nothing: no `if_rst_o` pulse appears and `if_en_o` stays 1.
- R2: After an inactive run of at least RST_CYC but fewer than DIS_CYC cycles (default 1229), the return of the power-status input gives exactly one `if_rst_o` pulse, one cycle wide, and `if_en_o` stays 1 for the whole episode.
- R3: An inactive run of DIS_CYC cycles or more clears `if_en_o` while the input is still low. When the input returns, `if_en_o` goes back to 1 and exactly one `if_rst_o` pulse is issued.
- R4: While the synchronised power-status level is low, the wake output starts when any of these holds: a `linkon_pkt_i` pulse, `port_evt_i` = 1, or `wdog_i` = 1 together with any of `timeout_i`, `pwr_fail_i` or `loop_i`. When `wdog_i` = 0, the timeout, power-fail and loop flags have no effect.
- R5: While active, `wake_o` is a square wave with a period of WAKE_DIV system clock cycles (default 8): low for the first half of the period and high for the second. It is 0 while inactive.
- R6: Once started, the wake output stays active until the power-status input goes high. It stops no more than SYNC_STAGES+2 cycles after that.
- R7: A `bus_rst_i` pulse stops the wake output only when a link-on packet alone started it. If a port event or a watchdog-qualified flag was seen during the inactive period, or is present now, the bus reset has no effect.
- R8: When a wake condition is present while the power-status input is high, the wake output starts as soon as the synchronised level goes low.
- R9: `lowpwr_o` is 1 when `if_en_o` = 0, `ports_idle_i` = 1, the synchronised power-status level is low and `port_evt_i` = 0. It falls no more than SYNC_STAGES+1 cycles after the power-status input rises, or one cycle after `port_evt_i` or `ports_idle_i` changes to the other state.
- R10: When the power-status input rises after a disabled period, `if_en_o` is 1 within SYNC_STAGES+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lps_i | input | 1 | Link power-status level, asynchronous |
| linkon_pkt_i | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset occurred |
| port_evt_i | input | 1 | Port event flag |
| timeout_i | input | 1 | Timeout flag |
| pwr_fail_i | input | 1 | Cable power-fail flag |
| loop_i | input | 1 | Loop detected flag |
| wdog_i | input | 1 | Watchdog flag that qualifies the timeout, power-fail and loop flags |
| ports_idle_i | input | 1 | Every port is disconnected, disabled or suspended |
| if_rst_o | output | 1 | One-cycle reset pulse for the PHY-to-link interface |
| if_en_o | output | 1 | PHY-to-link interface enable |
| wake_o | output | 1 | Divided-clock wake signal toward the link |
| lowpwr_o | output | 1 | Low-power mode may be entered |

## Verification
The classifier is tried with inactive runs of 10, 58, 59, 300, 1228 and 1229 cycles. The pairs on either side of each threshold show that both limits fall at the exact cycle count, and the middle values show the ordinary reset case. The wake path is tried with a packet on its own and with a port event, so that a following bus reset shows the two cases apart. Timeout with and without the watchdog flag shows the qualification. A port event raised while the link is powered shows the pending start. Low-power entry is tried with the port-idle flag toggled, and exit is tried through a port event and through power-status return.

// File: rtl/linkpwr_pkg.sv
package linkpwr_pkg;

   typedef struct packed {
      logic port_evt;
      logic timeout;
      logic pwr_fail;
      logic loop_det;
      logic wdog;
   } wake_flags_t;

   function automatic logic flags_wake(input wake_flags_t f);
      return f.port_evt | (f.wdog & (f.timeout | f.pwr_fail | f.loop_det));
   endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lpm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_idle_class.sv
module lpm_idle_class #(
   parameter int RST_CYC = 59,
   parameter int DIS_CYC = 1229
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lps_s_i,
   output logic if_rst_o,
   output logic if_en_o
);
   if (RST_CYC < 1 || DIS_CYC <= RST_CYC) begin : g_bad_thr
      $error("lpm_idle_class: need 1 <= RST_CYC < DIS_CYC");
   end

   localparam int CW = $clog2(DIS_CYC + 1);
   localparam logic [CW-1:0] SAT   = CW'(DIS_CYC);
   localparam logic [CW-1:0] DIS_M = CW'(DIS_CYC - 1);
   localparam logic [CW-1:0] RST_T = CW'(RST_CYC);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q    <= '0;
         if_en_o  <= 1'b1;
         if_rst_o <= 1'b0;
      end else begin
         if_rst_o <= 1'b0;
         if (!lps_s_i) begin
            if (run_q != SAT) run_q <= run_q + 1'b1;
            if (run_q == DIS_M) if_en_o <= 1'b0;
         end else begin
            if (run_q >= RST_T) if_rst_o <= 1'b1;
            if_en_o <= 1'b1;
            run_q   <= '0;
         end
      end
   end

   assert_rst_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      if_rst_o |=> !if_rst_o);
   assert_disabled_long_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lps_s_i && run_q == SAT) |-> !if_en_o);
   assert_reenable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lps_s_i |=> if_en_o);
endmodule

// File: rtl/lpm_wake_gen.sv
module lpm_wake_gen
   import linkpwr_pkg::*;
#(
   parameter int WAKE_DIV = 8
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        lps_s_i,
   input  logic        linkon_pkt_i,
   input  logic        bus_rst_i,
   input  wake_flags_t flags_i,
   output logic        wake_o
);
   if (WAKE_DIV < 2 || (WAKE_DIV % 2) != 0) begin : g_bad_div
      $error("lpm_wake_gen: WAKE_DIV must be even and at least 2");
   end

   localparam int DW = $clog2(WAKE_DIV);
   localparam logic [DW-1:0] HALF = DW'(WAKE_DIV / 2);
   localparam logic [DW-1:0] LAST = DW'(WAKE_DIV - 1);

   logic          cond;
   logic          pkt_q, flag_hit_q, active_q;
   logic [DW-1:0] div_q;

   assign cond = flags_wake(flags_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pkt_q      <= 1'b0;
         flag_hit_q <= 1'b0;
         active_q   <= 1'b0;
      end else if (lps_s_i) begin
         pkt_q      <= 1'b0;
         flag_hit_q <= 1'b0;
         active_q   <= 1'b0;
      end else if (bus_rst_i && !cond && !flag_hit_q) begin
         pkt_q    <= 1'b0;
         active_q <= 1'b0;
      end else begin
         if (linkon_pkt_i) pkt_q      <= 1'b1;
         if (cond)         flag_hit_q <= 1'b1;
         if (linkon_pkt_i || pkt_q || cond) active_q <= 1'b1;
      end
   end

   if ((WAKE_DIV & (WAKE_DIV - 1)) == 0) begin : g_div_pow2
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        div_q <= '0;
         else if (!active_q) div_q <= '0;
         else                div_q <= div_q + 1'b1;
      end
      assign wake_o = div_q[DW-1];
   end else begin : g_div_any
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)            div_q <= '0;
         else if (!active_q)     div_q <= '0;
         else if (div_q == LAST) div_q <= '0;
         else                    div_q <= div_q + 1'b1;
      end
      assign wake_o = (div_q >= HALF);
   end

   assert_wake_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lps_s_i |=> !active_q);
   assert_wake_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_q) |-> $past(!lps_s_i));
   assert_wake_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_q) |-> !wake_o);
endmodule

// File: rtl/linkpwr_mon.sv
module linkpwr_mon
   import linkpwr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 59,
   parameter int DIS_CYC     = 1229,
   parameter int WAKE_DIV    = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lps_i,
   input  logic linkon_pkt_i,
   input  logic bus_rst_i,
   input  logic port_evt_i,
   input  logic timeout_i,
   input  logic pwr_fail_i,
   input  logic loop_i,
   input  logic wdog_i,
   input  logic ports_idle_i,
   output logic if_rst_o,
   output logic if_en_o,
   output logic wake_o,
   output logic lowpwr_o
);
   logic        lps_s;
   wake_flags_t flags;

   assign flags = '{port_evt: port_evt_i, timeout: timeout_i, pwr_fail: pwr_fail_i,
                    loop_det: loop_i, wdog: wdog_i};

   lpm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (lps_i), .q_o (lps_s));

   lpm_idle_class #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_class (
      .clk_i (clk_i), .rst_ni (rst_ni), .lps_s_i (lps_s),
      .if_rst_o (if_rst_o), .if_en_o (if_en_o));

   lpm_wake_gen #(.WAKE_DIV(WAKE_DIV)) u_wake (
      .clk_i (clk_i), .rst_ni (rst_ni), .lps_s_i (lps_s),
      .linkon_pkt_i (linkon_pkt_i), .bus_rst_i (bus_rst_i),
      .flags_i (flags), .wake_o (wake_o));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lowpwr_o <= 1'b0;
      else         lowpwr_o <= !if_en_o && ports_idle_i && !lps_s && !port_evt_i;
   end

   assert_lowpwr_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lps_s || port_evt_i || !ports_idle_i) |=> !lowpwr_o);
   assert_lowpwr_needs_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lowpwr_o |-> !if_rst_o);
endmodule

// File: tb/linkpwr_mon_tb_top.sv
module linkpwr_mon_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lps = 1'b1, pkt = 1'b0, brst = 1'b0, pevt = 1'b0;
   logic tmo = 1'b0, pfail = 1'b0, loopf = 1'b0, wdog = 1'b0, idle = 1'b0;
   logic if_rst, if_en, wake, lowpwr;

   int n_chk = 0, n_fail = 0;
   int rst_pulses = 0;
   logic en_min = 1'b1;

   always #5 clk = ~clk;

   linkpwr_mon dut_i (
      .clk_i (clk), .rst_ni (rst_n), .lps_i (lps), .linkon_pkt_i (pkt),
      .bus_rst_i (brst), .port_evt_i (pevt), .timeout_i (tmo), .pwr_fail_i (pfail),
      .loop_i (loopf), .wdog_i (wdog), .ports_idle_i (idle),
      .if_rst_o (if_rst), .if_en_o (if_en), .wake_o (wake), .lowpwr_o (lowpwr));

   always @(negedge clk) begin
      if (if_rst) rst_pulses++;
      if (!if_en) en_min = 1'b0;
   end

   // inactive run length, expected reset pulses, expected disable seen
   localparam int NV = 6;
   localparam int RUN  [NV] = '{10, 58, 59, 300, 1228, 1229};
   localparam int EXPR [NV] = '{0, 0, 1, 1, 1, 1};
   localparam int EXPD [NV] = '{0, 0, 0, 0, 0, 1};

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wake_rises(input int n, output int rises);
      logic prev;
      rises = 0;
      @(negedge clk);
      prev = wake;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wake && !prev) rises++;
         prev = wake;
      end
   endtask

   initial begin : watchdog
      #1500000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int r, p0;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 reset if_en", int'(if_en), 1);
      chk("R5 reset wake", int'(wake), 0);
      chk("R9 reset lowpwr", int'(lowpwr), 0);

      for (int v = 0; v < NV; v++) begin
         p0 = rst_pulses;
         en_min = 1'b1;
         lps = 1'b0;
         cyc(RUN[v]);
         lps = 1'b1;
         cyc(10);
         if (v < 2) chk("R1 short run pulses", rst_pulses - p0, EXPR[v]);
         else if (v < 5) chk("R2 mid run pulses", rst_pulses - p0, EXPR[v]);
         else chk("R3 long run pulses", rst_pulses - p0, EXPR[v]);
         chk(v == 5 ? "R3 disable seen" : "R2 enable held", int'(!en_min), EXPD[v]);
         chk("R10 enabled after return", int'(if_en), 1);
      end

      // R4 / R7: packet only, then bus reset stops it
      lps = 1'b0;
      cyc(4);
      chk("R4 no wake without cause", int'(wake), 0);
      pkt = 1'b1; cyc(1); pkt = 1'b0;
      wake_rises(32, r);
      chk("R5 wake period from packet", r, 4);
      brst = 1'b1; cyc(1); brst = 1'b0;
      cyc(2);
      wake_rises(16, r);
      chk("R7 bus reset stops packet wake", r, 0);
      // R4: port event, bus reset ignored
      pevt = 1'b1;
      wake_rises(32, r);
      chk("R4 port event wake", r, 4);
      brst = 1'b1; cyc(1); brst = 1'b0;
      pevt = 1'b0;
      brst = 1'b1; cyc(1); brst = 1'b0;
      wake_rises(32, r);
      chk("R7 bus reset ignored after port event", r, 4);
      lps = 1'b1;
      cyc(4);
      wake_rises(16, r);
      chk("R6 wake stops on power return", r, 0);
      chk("R6 wake level low", int'(wake), 0);

      // R4: watchdog qualification
      tmo = 1'b1;
      lps = 1'b0;
      cyc(4);
      wake_rises(16, r);
      chk("R4 timeout without watchdog", r, 0);
      wdog = 1'b1;
      wake_rises(32, r);
      chk("R4 timeout with watchdog", r, 4);
      lps = 1'b1;
      tmo = 1'b0; wdog = 1'b0;
      cyc(4);

      // R8: condition present while powered
      pevt = 1'b1;
      wake_rises(16, r);
      chk("R8 no wake while powered", r, 0);
      lps = 1'b0;
      cyc(2);
      wake_rises(32, r);
      chk("R8 pending wake starts", r, 4);
      lps = 1'b1;
      pevt = 1'b0;
      cyc(6);

      // R9 low power
      idle = 1'b1;
      lps = 1'b0;
      cyc(1240);
      chk("R3 disabled before low power", int'(if_en), 0);
      chk("R9 low power entered", int'(lowpwr), 1);
      idle = 1'b0;
      cyc(1);
      chk("R9 busy port leaves low power", int'(lowpwr), 0);
      idle = 1'b1;
      cyc(2);
      chk("R9 low power again", int'(lowpwr), 1);
      pevt = 1'b1;
      cyc(1);
      chk("R9 port event leaves low power", int'(lowpwr), 0);
      pevt = 1'b0;
      cyc(2);
      lps = 1'b1;
      cyc(4);
      chk("R9 power return leaves low power", int'(lowpwr), 0);
      chk("R10 enable within latency", int'(if_en), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule